// File: doc/BRIEF.md
# Exception Entry and Vector Controller

This block performs the register side of a processor taking an exception. Each cycle it may accept one request. The request names an entry class and a sub-code. It also carries the faulting PC, a delay-slot flag, a refill flag, a coprocessor number, and the current status, cause and vector-base register values. On the next clock edge the block publishes four things: the return address for that class, the updated status and cause words, any debug event flags, and the PC at which fetch must resume.

There are three entry paths, and each has its own return register. The general path covers ordinary exceptions and interrupts. It fills the exception PC only when the status exception-level bit is clear, and it picks a vector offset from the interrupt-vector bit, the refill flag and that exception-level bit. The error path covers NMI and soft reset. It writes the error PC and jumps to the boot vector. The debug path records a debug event, writes the debug PC, enters debug mode and jumps to the debug vector.

A small state machine holds the last path taken. It has four states: `PATH_IDLE` (0), `PATH_GENERAL` (1), `PATH_ERROR` (2) and `PATH_DEBUG` (3). Reset places it in `PATH_IDLE`. From any state, an accepted request moves it to the state of that request's class. A cycle with no accepted request leaves the state unchanged.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset: `epc`, `err_pc`, `dbg_pc`, `status_out`, `cause_out` and `dbg_flags` are zero. `dbg_mode`, `watch_clr` and `entry_strobe` are low, `next_pc` is 0xBFC00000 and `entry_path` is 0.
- R2: A request with `req_class`=0 (general) is accepted. The cycle after it, `cause_out` bits 6:2 equal `req_sub`, and every other cause bit comes from `cause_in` unless R5 or R7 changes it.
- R3: On the general path the vector offset is chosen as follows. It is 0x200 for code 0 when `cause_in` bit 23 is set. It is 0x000 for code 2 or 3 when `tlb_refill` is set and `status_in` bit 1 (EXL) is clear. Otherwise it is 0x180.
- R4: On the general path, `next_pc` is the base plus the offset from R3. The base is 0xBFC00200 when `status_in` bit 22 (BEV) is set. Otherwise it is `vbase_in` with bits 9:0 cleared.
- R5: A general request that arrives with EXL clear does four things. It sets `epc` to `pc`-4 if `in_dslot` is set, and to `pc` otherwise. It sets cause bit 31 (BD) equal to `in_dslot`. It sets status bit 1, and it clears status bit 4 (user mode).
- R6: A general request that arrives with EXL set leaves `epc` unchanged. In that case `status_out` equals `status_in`, and cause bit 31 equals `cause_in` bit 31.
- R7: General code 11 writes `cop_num` into cause bits 29:28. Every other general code keeps `cause_in` bits 29:28.
- R8: `req_class`=1 is the error path. `req_sub` bit 0 selects the event: 0 is NMI and sets status bit 19, and 1 is soft reset and sets status bit 20. The error path sets status bits 2 and 22 and clears bit 4. It writes `err_pc` as `pc`-4 in a delay slot and `pc` otherwise, and sets `next_pc` to 0xBFC00000. It clears BD when EXL is clear and keeps BD otherwise. `watch_clr` pulses for one cycle on soft reset only.
- R9: `req_class`=2 with `req_sub` from 0 to 5 is the debug path. It sets `dbg_flags` bit `req_sub`, and the flags accumulate. `dbg_pc` is `pc`-4 when in a delay slot and `req_sub` is not 0 (single-step); otherwise it is `pc`. The path sets `dbg_mode` and `next_pc` = 0xBFC00480. `status_out` equals `status_in`, and BD is cleared when EXL is clear.
- R10: Some cycles carry no request the block accepts: `req` is low, `req_class`=3, or a debug request has `req_sub` above 5. In those cycles every output holds its value, except that `entry_strobe` and `watch_clr` are low.
- R11: `entry_strobe` is high for exactly the cycle after each accepted request. `entry_path` shows the state of the last accepted request: 1 for general, 2 for error, 3 for debug.
- R12: Requests on consecutive cycles are each applied in full, one per clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Request valid |
| req_class | input | 2 | 0 general, 1 error, 2 debug, 3 none |
| req_sub | input | 5 | Cause code, error selector, or debug event index |
| pc | input | ADDR_W | PC of the faulting instruction |
| in_dslot | input | 1 | Faulting instruction is in a branch delay slot |
| tlb_refill | input | 1 | TLB miss has no matching entry (refill) |
| cop_num | input | 2 | Coprocessor number for code 11 |
| status_in | input | 32 | Current status word |
| cause_in | input | 32 | Current cause word |
| vbase_in | input | ADDR_W | Current exception vector base |
| epc | output | ADDR_W | Exception return address |
| err_pc | output | ADDR_W | Error return address |
| dbg_pc | output | ADDR_W | Debug return address |
| status_out | output | 32 | Updated status word |
| cause_out | output | 32 | Updated cause word |
| dbg_flags | output | DBG_EVENTS | Sticky debug event flags |
| dbg_mode | output | 1 | Debug mode entered |
| watch_clr | output | 1 | One-cycle pulse to clear the watch register |
| next_pc | output | ADDR_W | Resume fetch address |
| entry_strobe | output | 1 | Outputs were updated by an accepted request |
| entry_path | output | 2 | Last path taken |

## Verification
A wrong path state or a mis-decoded class becomes visible one clock after the request. It shows as the wrong return register moving, the wrong vector on `next_pc`, or a mismatch on `entry_path`. Corrupted retained state behaves differently: a stale `epc`, a lost sticky debug flag, or a `dbg_mode` that never sets can stay hidden through many general requests made with EXL set. It surfaces only when a later request reads it back through the ports. For that reason the bench compares every output on every cycle against a running model, so a divergence is flagged in the cycle where it first appears.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int REG_W = 32;
    localparam int EC_W  = 5;

    typedef enum logic [1:0] {
        CLS_GENERAL = 2'd0,
        CLS_ERROR   = 2'd1,
        CLS_DEBUG   = 2'd2,
        CLS_NONE    = 2'd3
    } exc_class_e;

    typedef enum logic [1:0] {
        PATH_IDLE    = 2'd0,
        PATH_GENERAL = 2'd1,
        PATH_ERROR   = 2'd2,
        PATH_DEBUG   = 2'd3
    } entry_path_e;

    // status word bit positions
    localparam int ST_EXL  = 1;
    localparam int ST_ERL  = 2;
    localparam int ST_USER = 4;
    localparam int ST_NMI  = 19;
    localparam int ST_SRST = 20;
    localparam int ST_BEV  = 22;

    // cause word bit positions
    localparam int CA_EC_LO = 2;
    localparam int CA_IV    = 23;
    localparam int CA_CE_LO = 28;
    localparam int CA_BD    = 31;

    // cause codes with special handling
    localparam logic [EC_W-1:0] EC_INT  = 5'd0;
    localparam logic [EC_W-1:0] EC_TLBL = 5'd2;
    localparam logic [EC_W-1:0] EC_TLBS = 5'd3;
    localparam logic [EC_W-1:0] EC_CPU  = 5'd11;

    localparam logic [EC_W-1:0] DBG_SSTEP = 5'd0;
endpackage

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
    import exc_entry_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [EC_W-1:0]   code,
    input  logic              iv,
    input  logic              refill,
    input  logic              exl,
    input  logic              bev,
    input  logic [ADDR_W-1:0] vbase,
    output logic [ADDR_W-1:0] vector
);
    localparam int                VB_LOW    = 10;
    localparam logic [ADDR_W-1:0] BOOT_BASE = ADDR_W'(32'hBFC0_0200);
    localparam logic [ADDR_W-1:0] OFF_GEN   = ADDR_W'(12'h180);
    localparam logic [ADDR_W-1:0] OFF_INT   = ADDR_W'(12'h200);

    logic [ADDR_W-1:0] offset;
    logic [ADDR_W-1:0] base;

    always_comb begin
        offset = OFF_GEN;
        if (code == EC_INT && iv) begin
            offset = OFF_INT;
        end else if ((code == EC_TLBL || code == EC_TLBS) && refill && !exl) begin
            offset = '0;
        end
        base   = bev ? BOOT_BASE : {vbase[ADDR_W-1:VB_LOW], {VB_LOW{1'b0}}};
        vector = base + offset;
    end
endmodule

// File: rtl/exc_ret_addr.sv
module exc_ret_addr #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic              in_dslot,
    input  logic              slot_exempt,
    output logic [ADDR_W-1:0] ret_addr
);
    localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(4);

    // point back at the branch when the faulting instruction sits in its slot
    assign ret_addr = (in_dslot && !slot_exempt) ? (pc - INSN_BYTES) : pc;
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DBG_EVENTS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req,
    input  logic [1:0]            req_class,
    input  logic [4:0]            req_sub,
    input  logic [ADDR_W-1:0]     pc,
    input  logic                  in_dslot,
    input  logic                  tlb_refill,
    input  logic [1:0]            cop_num,
    input  logic [31:0]           status_in,
    input  logic [31:0]           cause_in,
    input  logic [ADDR_W-1:0]     vbase_in,
    output logic [ADDR_W-1:0]     epc,
    output logic [ADDR_W-1:0]     err_pc,
    output logic [ADDR_W-1:0]     dbg_pc,
    output logic [31:0]           status_out,
    output logic [31:0]           cause_out,
    output logic [DBG_EVENTS-1:0] dbg_flags,
    output logic                  dbg_mode,
    output logic                  watch_clr,
    output logic [ADDR_W-1:0]     next_pc,
    output logic                  entry_strobe,
    output logic [1:0]            entry_path
);
    localparam logic [ADDR_W-1:0] RESET_VEC = ADDR_W'(32'hBFC0_0000);
    localparam logic [ADDR_W-1:0] DEBUG_VEC = ADDR_W'(32'hBFC0_0480);

    exc_class_e  cls;
    entry_path_e state_q, state_d;
    logic        exl, dbg_sub_ok, accept, single_step;
    logic [ADDR_W-1:0] gen_vec, ret_addr;

    logic [ADDR_W-1:0]     nx_epc, nx_err, nx_dpc, nx_np;
    logic [REG_W-1:0]      nx_st, nx_ca;
    logic [DBG_EVENTS-1:0] nx_fl;
    logic                  nx_dm, nx_wc;

    assign cls         = exc_class_e'(req_class);
    assign exl         = status_in[ST_EXL];
    assign dbg_sub_ok  = int'(req_sub) < DBG_EVENTS;
    assign single_step = (cls == CLS_DEBUG) && (req_sub == DBG_SSTEP);
    assign accept      = req && ((cls == CLS_GENERAL) || (cls == CLS_ERROR)
                                 || (cls == CLS_DEBUG && dbg_sub_ok));

    exc_vector_sel #(.ADDR_W(ADDR_W)) u_vec (
        .code   (req_sub),
        .iv     (cause_in[CA_IV]),
        .refill (tlb_refill),
        .exl    (exl),
        .bev    (status_in[ST_BEV]),
        .vbase  (vbase_in),
        .vector (gen_vec)
    );

    exc_ret_addr #(.ADDR_W(ADDR_W)) u_ret (
        .pc          (pc),
        .in_dslot    (in_dslot),
        .slot_exempt (single_step),
        .ret_addr    (ret_addr)
    );

    // next path state
    always_comb begin
        state_d = state_q;
        if (accept) begin
            unique case (cls)
                CLS_GENERAL: state_d = PATH_GENERAL;
                CLS_ERROR:   state_d = PATH_ERROR;
                CLS_DEBUG:   state_d = PATH_DEBUG;
                CLS_NONE:    state_d = state_q;
            endcase
        end
    end

    // next output values for each path
    always_comb begin
        nx_epc = epc;
        nx_err = err_pc;
        nx_dpc = dbg_pc;
        nx_st  = status_out;
        nx_ca  = cause_out;
        nx_fl  = dbg_flags;
        nx_dm  = dbg_mode;
        nx_np  = next_pc;
        nx_wc  = 1'b0;
        if (accept) begin
            nx_st = status_in;
            nx_ca = cause_in;
            unique case (cls)
                CLS_GENERAL: begin
                    if (!exl) begin
                        nx_epc          = ret_addr;
                        nx_ca[CA_BD]    = in_dslot;
                        nx_st[ST_EXL]   = 1'b1;
                        nx_st[ST_USER]  = 1'b0;
                    end
                    if (req_sub == EC_CPU) begin
                        nx_ca[CA_CE_LO +: 2] = cop_num;
                    end
                    nx_ca[CA_EC_LO +: EC_W] = req_sub;
                    nx_np = gen_vec;
                end
                CLS_ERROR: begin
                    nx_err         = ret_addr;
                    nx_st[ST_ERL]  = 1'b1;
                    nx_st[ST_BEV]  = 1'b1;
                    nx_st[ST_USER] = 1'b0;
                    if (req_sub[0]) begin
                        nx_st[ST_SRST] = 1'b1;
                        nx_wc          = 1'b1;
                    end else begin
                        nx_st[ST_NMI]  = 1'b1;
                    end
                    if (!exl) nx_ca[CA_BD] = 1'b0;
                    nx_np = RESET_VEC;
                end
                CLS_DEBUG: begin
                    nx_dpc = ret_addr;
                    nx_fl  = dbg_flags | (DBG_EVENTS'(1) << req_sub);
                    nx_dm  = 1'b1;
                    if (!exl) nx_ca[CA_BD] = 1'b0;
                    nx_np = DEBUG_VEC;
                end
                CLS_NONE: begin
                    nx_st = status_out;
                    nx_ca = cause_out;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PATH_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            epc          <= '0;
            err_pc       <= '0;
            dbg_pc       <= '0;
            status_out   <= '0;
            cause_out    <= '0;
            dbg_flags    <= '0;
            dbg_mode     <= 1'b0;
            watch_clr    <= 1'b0;
            next_pc      <= RESET_VEC;
            entry_strobe <= 1'b0;
        end else begin
            epc          <= nx_epc;
            err_pc       <= nx_err;
            dbg_pc       <= nx_dpc;
            status_out   <= nx_st;
            cause_out    <= nx_ca;
            dbg_flags    <= nx_fl;
            dbg_mode     <= nx_dm;
            watch_clr    <= nx_wc;
            next_pc      <= nx_np;
            entry_strobe <= accept;
        end
    end

    assign entry_path = state_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req,
    input logic [1:0]        req_class,
    input logic [4:0]        req_sub,
    input logic [31:0]       status_in,
    input logic [ADDR_W-1:0] epc,
    input logic [31:0]       status_out,
    input logic [31:0]       cause_out,
    input logic              dbg_mode,
    input logic              watch_clr,
    input logic [ADDR_W-1:0] next_pc,
    input logic              entry_strobe,
    input logic [1:0]        entry_path
);
    localparam logic [ADDR_W-1:0] RST_V = ADDR_W'(32'hBFC0_0000);
    localparam logic [ADDR_W-1:0] DBG_V = ADDR_W'(32'hBFC0_0480);

    p_ec_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && req_class == 2'd0) |=> cause_out[6:2] == $past(req_sub));

    p_exl_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req && req_class == 2'd0 && !status_in[1]) |=> (status_out[1] && !status_out[4]));

    p_epc_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req && req_class == 2'd0 && status_in[1]) |=> $stable(epc));

    p_error_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && req_class == 2'd1) |=> (next_pc == RST_V && status_out[2] && status_out[22]));

    p_watch_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
        watch_clr |-> entry_path == 2'd2);

    p_sstep_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && req_class == 2'd2 && req_sub == 5'd0) |=> (dbg_mode && next_pc == DBG_V));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> (!entry_strobe && !watch_clr && $stable(next_pc) && $stable(epc)));

    p_strobe_path_r11: assert property (@(posedge clk) disable iff (!rst_n)
        entry_strobe |-> entry_path != 2'd0);
endmodule

bind exc_entry_ctrl exc_entry_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [1:0]  req_class = '0;
    logic [4:0]  req_sub = '0;
    logic [31:0] pc = '0;
    logic        in_dslot = 1'b0;
    logic        tlb_refill = 1'b0;
    logic [1:0]  cop_num = '0;
    logic [31:0] status_in = '0;
    logic [31:0] cause_in = '0;
    logic [31:0] vbase_in = '0;
    logic [31:0] epc, err_pc, dbg_pc, status_out, cause_out, next_pc;
    logic [5:0]  dbg_flags;
    logic        dbg_mode, watch_clr, entry_strobe;
    logic [1:0]  entry_path;

    int checks = 0;
    int errors = 0;

    // running model of expected outputs
    logic [31:0] m_epc = '0, m_err = '0, m_dpc = '0, m_st = '0, m_ca = '0;
    logic [31:0] m_np = 32'hBFC0_0000;
    logic [5:0]  m_fl = '0;
    logic        m_dm = 1'b0, m_wc = 1'b0, m_stb = 1'b0;
    logic [1:0]  m_path = 2'd0;

    always #5 clk = ~clk;

    exc_entry_ctrl dut (.*);

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, "epc", epc, m_epc);
        chk(tag, "err_pc", err_pc, m_err);
        chk(tag, "dbg_pc", dbg_pc, m_dpc);
        chk(tag, "status", status_out, m_st);
        chk(tag, "cause", cause_out, m_ca);
        chk(tag, "flags", 32'(dbg_flags), 32'(m_fl));
        chk(tag, "dbg_mode", 32'(dbg_mode), 32'(m_dm));
        chk(tag, "watch_clr", 32'(watch_clr), 32'(m_wc));
        chk(tag, "next_pc", next_pc, m_np);
        chk(tag, "strobe", 32'(entry_strobe), 32'(m_stb));
        chk(tag, "path", 32'(entry_path), 32'(m_path));
    endtask

    function automatic logic [31:0] gen_vector(input logic [4:0] code, input logic [31:0] st,
                                               input logic [31:0] ca, input logic [31:0] vb,
                                               input logic rf);
        logic [31:0] off, base;
        off = 32'h180;
        if (code == 5'd0 && ca[23]) off = 32'h200;
        else if ((code == 5'd2 || code == 5'd3) && rf && !st[1]) off = 32'h0;
        base = st[22] ? 32'hBFC0_0200 : (vb & 32'hFFFF_FC00);
        return base + off;
    endfunction

    task automatic model(input logic r, input logic [1:0] c, input logic [4:0] s, input logic [31:0] p,
                         input logic ds, input logic rf, input logic [1:0] cp,
                         input logic [31:0] st, input logic [31:0] ca, input logic [31:0] vb);
        logic [31:0] ret;
        ret = ds ? p - 32'd4 : p;
        m_wc = 1'b0;
        m_stb = 1'b0;
        if (!r || c == 2'd3 || (c == 2'd2 && s > 5'd5)) return;
        m_stb = 1'b1;
        m_st = st;
        m_ca = ca;
        if (c == 2'd0) begin
            m_path = 2'd1;
            if (!st[1]) begin
                m_epc = ret;
                m_ca[31] = ds;
                m_st[1] = 1'b1;
                m_st[4] = 1'b0;
            end
            if (s == 5'd11) m_ca[29:28] = cp;
            m_ca[6:2] = s;
            m_np = gen_vector(s, st, ca, vb, rf);
        end else if (c == 2'd1) begin
            m_path = 2'd2;
            m_err = ret;
            m_st[2] = 1'b1;
            m_st[22] = 1'b1;
            m_st[4] = 1'b0;
            if (s[0]) begin
                m_st[20] = 1'b1;
                m_wc = 1'b1;
            end else begin
                m_st[19] = 1'b1;
            end
            if (!st[1]) m_ca[31] = 1'b0;
            m_np = 32'hBFC0_0000;
        end else begin
            m_path = 2'd3;
            m_dpc = (ds && s != 5'd0) ? p - 32'd4 : p;
            m_fl[s] = 1'b1;
            m_dm = 1'b1;
            if (!st[1]) m_ca[31] = 1'b0;
            m_np = 32'hBFC0_0480;
        end
    endtask

    // drive at a falling edge, compare at the next falling edge
    task automatic do_req(input logic r, input logic [1:0] c, input logic [4:0] s, input logic [31:0] p,
                          input logic ds, input logic rf, input logic [1:0] cp,
                          input logic [31:0] st, input logic [31:0] ca, input logic [31:0] vb,
                          input string tag);
        req = r; req_class = c; req_sub = s; pc = p; in_dslot = ds; tlb_refill = rf;
        cop_num = cp; status_in = st; cause_in = ca; vbase_in = vb;
        model(r, c, s, p, ds, rf, cp, st, ca, vb);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R12 watchdog: got running expected finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R3: vector offsets
        do_req(1, 2'd0, 5'd0, 32'h0040_1000, 0, 0, 0, 32'h10, 32'h0080_0000, 32'h8000_0000, "R3");
        do_req(1, 2'd0, 5'd0, 32'h0040_1004, 0, 0, 0, 32'h10, 32'h0, 32'h8000_0000, "R3");
        do_req(1, 2'd0, 5'd2, 32'h0040_1008, 0, 1, 0, 32'h10, 32'h0, 32'h8000_0000, "R3");
        do_req(1, 2'd0, 5'd3, 32'h0040_100C, 0, 1, 0, 32'h12, 32'h0, 32'h8000_0000, "R3");
        // R4: boot base, and low bits of vector base dropped
        do_req(1, 2'd0, 5'd8, 32'h0040_2000, 0, 0, 0, 32'h0040_0000, 32'h0, 32'h8000_0000, "R4");
        do_req(1, 2'd0, 5'd8, 32'h0040_2004, 0, 0, 0, 32'h0, 32'h0, 32'h8000_12FF, "R4");
        // R5: delay slot with EXL clear
        do_req(1, 2'd0, 5'd4, 32'h0040_3000, 1, 0, 0, 32'h11, 32'h0, 32'h8000_0000, "R5");
        // R6: EXL set, in a slot, BD from cause_in kept
        do_req(1, 2'd0, 5'd5, 32'h0040_3100, 1, 0, 0, 32'h13, 32'h0, 32'h8000_0000, "R6");
        // R7: coprocessor number written, then kept for another code
        do_req(1, 2'd0, 5'd11, 32'h0040_4000, 0, 0, 2'd3, 32'h0, 32'h0, 32'h8000_0000, "R7");
        do_req(1, 2'd0, 5'd12, 32'h0040_4004, 0, 0, 2'd3, 32'h0, 32'h1000_0000, 32'h8000_0000, "R7");
        // R8: soft reset then NMI in a slot
        do_req(1, 2'd1, 5'd1, 32'h0040_5000, 0, 0, 0, 32'h10, 32'h8000_0000, 32'h0, "R8");
        do_req(1, 2'd1, 5'd0, 32'h0040_5004, 1, 0, 0, 32'h12, 32'h8000_0000, 32'h0, "R8");
        // R9: single-step in slot keeps pc, breakpoint in slot backs up
        do_req(1, 2'd2, 5'd0, 32'h0040_6000, 1, 0, 0, 32'h0, 32'h8000_0000, 32'h0, "R9");
        do_req(1, 2'd2, 5'd3, 32'h0040_6004, 1, 0, 0, 32'h0, 32'h8000_0000, 32'h0, "R9");
        // R10: ignored requests
        do_req(1, 2'd3, 5'd4, 32'h0040_7000, 1, 0, 0, 32'hFFFF, 32'hFFFF, 32'h0, "R10");
        do_req(1, 2'd2, 5'd7, 32'h0040_7004, 0, 0, 0, 32'h0, 32'h0, 32'h0, "R10");
        do_req(0, 2'd0, 5'd9, 32'h0040_7008, 0, 0, 0, 32'h0, 32'h0, 32'h0, "R10");
        // R11/R12: back-to-back requests of different classes
        do_req(1, 2'd0, 5'd9, 32'h0040_8000, 0, 0, 0, 32'h0, 32'h0, 32'h9000_0000, "R12");
        do_req(1, 2'd1, 5'd1, 32'h0040_8004, 0, 0, 0, 32'h2, 32'h0, 32'h0, "R11");
        do_req(1, 2'd2, 5'd5, 32'h0040_8008, 0, 0, 0, 32'h2, 32'h0, 32'h0, "R12");

        // random stimulus
        for (int i = 0; i < 600; i++) begin
            logic        r;
            logic [1:0]  c;
            logic [4:0]  s;
            logic [2:0]  pick;
            string       tag;
            r = ($urandom % 10) != 0;
            pick = 3'($urandom % 8);
            c = (pick < 4) ? 2'd0 : (pick == 4) ? 2'd1 : (pick < 7) ? 2'd2 : 2'd3;
            s = (c == 2'd2) ? 5'($urandom % 8) : 5'($urandom % 32);
            if (!r || c == 2'd3 || (c == 2'd2 && s > 5'd5)) tag = "R10";
            else if (c == 2'd0) tag = "R2";
            else if (c == 2'd1) tag = "R8";
            else tag = "R9";
            do_req(r, c, s, $urandom & 32'hFFFF_FFFC, 1'($urandom), 1'($urandom), 2'($urandom),
                   $urandom, $urandom, $urandom, tag);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule